// File: doc/BRIEF.md
# Supply Monitor Deglitch and Event Router

This block cleans up the raw output of an analog supply-voltage comparator and turns it into chip-level events. The comparator level first crosses into the system clock domain through a short synchronizer. It then goes through a deglitch filter whose length software selects. The result is a filtered "supply low" status.

Depending on a mode bit, the filtered status either raises a chip-reset request or latches an interrupt line. A separate sticky event flag records every filtered crossing of the threshold, in either direction. Software clears that flag by writing a one to it.

The configuration holds an enable, the mode, a low-power hint, a stored threshold code and the filter select. It is guarded by an external unlock signal. The threshold code and the low-power hint are only held and presented to the analog side.

Top module: `supply_mon_router`

## Requirements
- R1: While reset is held, and right after it is released, `ctl_q`, `status`, `reset_req`, `irq` and `event_flag` are all 0.
- R2: A write (`cfg_we` high) copies `cfg_wdata[7:0]` into `ctl_q` only when `unlock` is high. With `unlock` low, `ctl_q` keeps its value. The fields of `ctl_q` are: bit 0 enable, bit 1 mode (1 = reset, 0 = interrupt), bit 2 low-power hint, bits 4:3 threshold code, bits 7:5 filter select.
- R3: While enable (`ctl_q[0]`) is 0, `status`, `reset_req` and `irq` are 0, whatever `cmp_raw` does.
- R4: For filter select codes 1 to 7, the filtered level changes only after the synchronized input has differed from it for N consecutive clocks, where N = 4 << (code-1), giving 4, 8, …, 256. When `cmp_raw` changes just before clock edge k and then holds, `status` changes right after edge k+N+1. A pulse that lasts N-1 clocks is ignored.
- R5: With filter select 0, the filtered level takes the synchronized input only on clock edges where `slow_tick` is high.
- R6: In reset mode (`ctl_q[1]`=1) with the block enabled, `reset_req` equals the filtered status and `irq` stays 0.
- R7: In interrupt mode with the block enabled, `irq` rises when the filtered level goes high. It stays high after the level falls, and it drops only once enable is cleared. `reset_req` stays 0 in this mode.
- R8: While enabled, `event_flag` sets in the same cycle that `status` rises or falls, in either mode. Turning the block off does not set it.
- R9: A write with `cfg_wdata[8]`=1 clears `event_flag`, whatever the level of `unlock`. A write with bit 8 at 0 leaves the flag as it is.
- R10: If a filtered transition and a clearing write fall on the same clock edge, `event_flag` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable marking a slow sampling clock edge |
| cmp_raw | input | 1 | Asynchronous comparator level, 1 = supply below threshold |
| unlock | input | 1 | Write-protection release for the configuration fields |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Write data: bits 7:0 are the configuration fields, bit 8 clears the event flag |
| ctl_q | output | 8 | Current configuration fields |
| status | output | 1 | Filtered supply-low status, forced to 0 when disabled |
| reset_req | output | 1 | Chip-reset request (reset mode) |
| irq | output | 1 | Latched interrupt (interrupt mode) |
| event_flag | output | 1 | Sticky flag set on each filtered transition |

## Verification
Every counted filter length is driven with a pulse one clock shorter than the limit and then with a level held exactly long enough. This separates an off-by-one in the counter from a wrong decode of the select code, because the output edge is sampled on both sides of the predicted cycle.

Random pulse widths straddle the limit for one mid-range code. These show that the flag follows only pulses at or above the limit. Slow mode is exercised with and without `slow_tick`, which proves that sampling waits for the enable. Random writes with random `unlock` compare the stored fields against a model of the protection.

A clearing write aligned to the cycle of a filtered transition tests the set-over-clear priority. Disabling the block while the status is high shows that the output drops without a flag.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  localparam int DGSEL_W = 3;
  localparam int THR_W   = 2;

  // Field order defines the bit layout of ctl_q and cfg_wdata[7:0].
  typedef struct packed {
    logic [DGSEL_W-1:0] dgsel;     // [7:5]
    logic [THR_W-1:0]   thr;       // [4:3]
    logic               lowpwr;    // [2]
    logic               rst_mode;  // [1]
    logic               en;        // [0]
  } vmon_ctl_t;

  localparam int CTL_W   = $bits(vmon_ctl_t);
  localparam int CLR_BIT = CTL_W;

endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_in};
  end

  assign q_out = sh_q[STAGES-1];

endmodule

// File: rtl/vmon_deglitch.sv
module vmon_deglitch #(
  parameter int BASE_LOG2 = 2,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             slow_tick,
  input  logic             lvl_sync,
  input  logic [SEL_W-1:0] sel,
  output logic             filt_q,
  output logic             filt_nx
);

  localparam int NCODES    = 2 ** SEL_W;
  localparam int MAX_SHIFT = BASE_LOG2 + NCODES - 2;
  localparam int CNT_W     = MAX_SHIFT + 1;

  // Required run length for each select code; code 0 uses slow sampling.
  logic [CNT_W-1:0] len_tab [NCODES];

  genvar g;
  generate
    for (g = 0; g < NCODES; g++) begin : g_len
      if (g == 0) begin : g_slow
        assign len_tab[g] = '0;
      end else begin : g_cnt
        assign len_tab[g] = CNT_W'(1) << (BASE_LOG2 + g - 1);
      end
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W:0]   cnt_inc;
  logic             differ;

  assign differ  = (lvl_sync != filt_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_nx  = '0;
    filt_nx = filt_q;
    if (!en) begin
      filt_nx = 1'b0;
    end else if (sel == '0) begin
      if (slow_tick) filt_nx = lvl_sync;
    end else if (differ) begin
      if (cnt_inc >= {1'b0, len_tab[sel]}) filt_nx = lvl_sync;
      else                                 cnt_nx  = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      filt_q <= filt_nx;
    end
  end

endmodule

// File: rtl/vmon_event.sv
module vmon_event (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rst_mode,
  input  logic filt_q,
  input  logic filt_nx,
  input  logic clr,
  output logic status,
  output logic reset_req,
  output logic irq,
  output logic flag
);

  logic flag_q, irq_hold_q, upd;

  assign upd = en && (filt_nx != filt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q     <= 1'b0;
      irq_hold_q <= 1'b0;
    end else begin
      if (upd)      flag_q <= 1'b1;   // hardware set wins
      else if (clr) flag_q <= 1'b0;
      if (!en)                       irq_hold_q <= 1'b0;
      else if (!rst_mode && filt_nx) irq_hold_q <= 1'b1;
    end
  end

  assign status    = en & filt_q;
  assign reset_req = en & rst_mode & filt_q;
  assign irq       = en & irq_hold_q;
  assign flag      = flag_q;

endmodule

// File: rtl/vmon_ctl_reg.sv
module vmon_ctl_reg
  import vmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic      unlock,
  input  vmon_ctl_t wdata,
  output vmon_ctl_t ctl_q
);

  always_ff @(posedge clk) begin
    if (rst)               ctl_q <= '0;
    else if (we && unlock) ctl_q <= wdata;
  end

endmodule

// File: rtl/supply_mon_router.sv
module supply_mon_router
  import vmon_pkg::*;
#(
  parameter int BASE_LOG2   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic               cmp_raw,
  input  logic               unlock,
  input  logic               cfg_we,
  input  logic [CTL_W:0]     cfg_wdata,
  output logic [CTL_W-1:0]   ctl_q,
  output logic               status,
  output logic               reset_req,
  output logic               irq,
  output logic               event_flag
);

  vmon_ctl_t wr_ctl, ctl_s;
  logic      lvl_sync, filt_q, filt_nx, clr;

  assign wr_ctl = vmon_ctl_t'(cfg_wdata[CTL_W-1:0]);
  assign clr    = cfg_we & cfg_wdata[CLR_BIT];
  assign ctl_q  = ctl_s;

  vmon_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .unlock(unlock),
    .wdata (wr_ctl),
    .ctl_q (ctl_s)
  );

  vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (cmp_raw),
    .q_out(lvl_sync)
  );

  vmon_deglitch #(.BASE_LOG2(BASE_LOG2), .SEL_W(DGSEL_W)) u_dg (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_s.en),
    .slow_tick(slow_tick),
    .lvl_sync (lvl_sync),
    .sel      (ctl_s.dgsel),
    .filt_q   (filt_q),
    .filt_nx  (filt_nx)
  );

  vmon_event u_evt (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_s.en),
    .rst_mode (ctl_s.rst_mode),
    .filt_q   (filt_q),
    .filt_nx  (filt_nx),
    .clr      (clr),
    .status   (status),
    .reset_req(reset_req),
    .irq      (irq),
    .flag     (event_flag)
  );

endmodule

// File: rtl/vmon_checker.sv
module vmon_checker
  import vmon_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             unlock,
  input logic             cfg_we,
  input logic [CTL_W:0]   cfg_wdata,
  input logic [CTL_W-1:0] ctl_q,
  input logic             status,
  input logic             reset_req,
  input logic             irq,
  input logic             event_flag
);

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && unlock) |=> $stable(ctl_q));

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[0] |-> (!status && !reset_req && !irq));

  assert_reset_route_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (status && ctl_q[1]));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> !ctl_q[0]);

  assert_flag_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && $past(ctl_q[0]) && (status != $past(status))) |-> event_flag);

  assert_flag_clear_src_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(event_flag) && !event_flag) |-> $past(cfg_we && cfg_wdata[CLR_BIT]));

endmodule

bind supply_mon_router vmon_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .unlock    (unlock),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .ctl_q     (ctl_q),
  .status    (status),
  .reset_req (reset_req),
  .irq       (irq),
  .event_flag(event_flag)
);

// File: tb/tb_supply_mon_router.sv
module tb_supply_mon_router;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, slow_tick, cmp_raw, unlock, cfg_we;
  logic [8:0] cfg_wdata;
  logic [7:0] ctl_q;
  logic       status, reset_req, irq, event_flag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_mon_router dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .cmp_raw(cmp_raw),
    .unlock(unlock), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_q(ctl_q), .status(status), .reset_req(reset_req),
    .irq(irq), .event_flag(event_flag)
  );

  // Filter length from the requirement: 4 << (code-1).
  function automatic int exp_len(input int code);
    return 4 << (code - 1);
  endfunction

  function automatic logic [8:0] cfg_word(input logic en, input logic mode, input int code);
    return {1'b0, 3'(code), 2'b00, 1'b0, mode, en};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [8:0] d, input logic unl);
    cfg_we = 1'b1; cfg_wdata = d; unlock = unl;
    tick(1);
    cfg_we = 1'b0; unlock = 1'b0;
  endtask

  task automatic clear_flag();
    wr(9'h100, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unused_seed;
    logic [7:0] model;
    unused_seed = $urandom(32'd20240611);
    rst = 1'b1; slow_tick = 1'b0; cmp_raw = 1'b0; unlock = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0;
    tick(4);
    chk("R1 ctl in reset", ctl_q, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 status", status, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flag", event_flag, 0);

    // R3: disabled block ignores the comparator
    cmp_raw = 1'b1; slow_tick = 1'b1;
    tick(40);
    chk("R3 status off", status, 0);
    chk("R3 reset_req off", reset_req, 0);
    chk("R3 irq off", irq, 0);
    cmp_raw = 1'b0; slow_tick = 1'b0;
    tick(5);

    // R2: protection of configuration fields
    wr(cfg_word(1'b1, 1'b0, 1), 1'b0);
    chk("R2 locked write ignored", ctl_q, 0);
    wr(9'h0F8, 1'b1);
    chk("R2 unlocked write", ctl_q, 8'hF8);
    model = 8'hF8;
    for (int i = 0; i < 60; i++) begin
      logic [8:0] d;
      logic u;
      d = 9'($urandom);
      u = 1'($urandom);
      wr(d, u);
      if (u) model = d[7:0];
      chk("R2 random write", ctl_q, model);
    end
    wr(9'h000, 1'b1);
    clear_flag();
    tick(3);

    // R4, R7, R8, R9 across every counted filter length, interrupt mode
    for (int c = 1; c < 8; c++) begin
      int n;
      n = exp_len(c);
      wr(cfg_word(1'b1, 1'b0, c), 1'b1);
      chk("R2 cfg", ctl_q, 32'(cfg_word(1'b1, 1'b0, c)));
      cmp_raw = 1'b1; tick(n - 1); cmp_raw = 1'b0;
      tick(n + 4);
      chk("R4 short pulse status", status, 0);
      chk("R4 short pulse flag", event_flag, 0);
      cmp_raw = 1'b1;
      tick(n + 1);
      chk("R4 before limit", status, 0);
      tick(1);
      chk("R4 at limit", status, 1);
      chk("R8 rise flag", event_flag, 1);
      chk("R7 irq rise", irq, 1);
      chk("R7 no reset_req", reset_req, 0);
      wr(9'h100, 1'b0);
      chk("R9 clear", event_flag, 0);
      wr(9'h000, 1'b0);
      chk("R9 zero write keeps", event_flag, 0);
      cmp_raw = 1'b0;
      tick(n + 1);
      chk("R4 fall before limit", status, 1);
      tick(1);
      chk("R4 fall at limit", status, 0);
      chk("R8 fall flag", event_flag, 1);
      chk("R7 irq persists", irq, 1);
      wr(9'h000, 1'b1);
      chk("R7 irq off when disabled", irq, 0);
      clear_flag();
      tick(3);
    end

    // R6: reset mode and R8: disable does not set flag
    wr(cfg_word(1'b1, 1'b1, 1), 1'b1);
    cmp_raw = 1'b1;
    tick(6);
    chk("R6 reset_req", reset_req, 1);
    chk("R6 irq quiet", irq, 0);
    chk("R8 flag reset mode", event_flag, 1);
    clear_flag();
    wr(9'h000, 1'b1);
    chk("R3 reset_req off", reset_req, 0);
    chk("R3 status off", status, 0);
    tick(3);
    chk("R8 disable no flag", event_flag, 0);
    cmp_raw = 1'b0;
    tick(5);

    // R5: slow sampling mode
    wr(cfg_word(1'b1, 1'b0, 0), 1'b1);
    cmp_raw = 1'b1;
    tick(20);
    chk("R5 waits for tick", status, 0);
    slow_tick = 1'b1; tick(1); slow_tick = 1'b0;
    chk("R5 sample on tick", status, 1);
    cmp_raw = 1'b0;
    tick(10);
    chk("R5 holds without tick", status, 1);
    slow_tick = 1'b1; tick(1); slow_tick = 1'b0;
    chk("R5 falls on tick", status, 0);
    wr(9'h000, 1'b1);
    clear_flag();
    tick(3);

    // R10: set beats clear in the same cycle
    wr(cfg_word(1'b1, 1'b0, 1), 1'b1);
    cmp_raw = 1'b1;
    tick(exp_len(1) + 1);
    chk("R10 flag before", event_flag, 0);
    cfg_we = 1'b1; cfg_wdata = 9'h100; unlock = 1'b0;
    tick(1);
    cfg_we = 1'b0;
    chk("R10 set wins", event_flag, 1);
    chk("R10 status", status, 1);
    cmp_raw = 1'b0;
    tick(exp_len(1) + 3);
    clear_flag();

    // R4 random pulse widths around the limit of code 2
    wr(cfg_word(1'b1, 1'b0, 2), 1'b1);
    tick(2);
    for (int i = 0; i < 30; i++) begin
      int w, n;
      n = exp_len(2);
      w = 1 + int'($urandom % 16);
      cmp_raw = 1'b1; tick(w); cmp_raw = 1'b0;
      tick(2 * n + 6);
      chk("R4 random pulse flag", event_flag, (w >= n) ? 1 : 0);
      chk("R4 random settle", status, 0);
      clear_flag();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule